// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the system side of a parallel NOR flash. It has separate chip-select, output-strobe and write-strobe lines, an address bus, a data bus split into output, input and output-enable, and a ready/busy input. A client asks for one of three operations on a valid/ready handshake: write one word, erase the sector that holds an address, or erase the whole array. The block expands the request into the flash's unlock-and-command write sequence. Each write is a bus cycle of three phases, setup, strobe and hold, and each phase lasts a parameter-set number of clocks. The block then waits for the flash's internal algorithm to finish. It gives no timing and no verification of its own for that algorithm.

Completion is found in one of two ways, chosen per request. In the first, the block reads status twice in a row and compares bit 6. Once both reads return the same value the operation is done. If bit 6 is still changing and the error flag in bit 5 is set, the block reads twice more. If bit 6 still changes, the operation failed, and the block writes the reset command before it answers. In the second way, the block waits a short settle time and then watches the ready/busy pin. In both ways a counter caps the number of polls, and an operation that reaches the cap ends with a timeout.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset all three strobes are high, the data bus is not driven, req_ready is 1 and resp_valid is 0.
- R2: A write request (req_op = 0) issues exactly four bus writes in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (req_addr, req_data).
- R3: A sector-erase request (req_op = 1) issues six writes: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (req_addr, 0x30). A whole-array erase (req_op = 2) issues the same first five writes and ends with (0x555, 0x10).
- R4: In every bus write, chip select is low with address and data driven for T_SETUP clocks before the write strobe falls. The strobe stays low for T_STROBE clocks, and chip select, address and data stay unchanged for T_HOLD clocks after it rises.
- R5: The output strobe is never low while the block drives the data bus or while the write strobe is low.
- R6: With req_rb_mode = 0, the block reports success once two consecutive status reads at the target address agree in bit 6.
- R7: If the two reads differ in bit 6 and the second has bit 5 set, the block reads twice more. If those two agree in bit 6 it reports success. If they differ it writes 0xF0 to address 0 and reports failure.
- R8: With req_rb_mode = 1, the block does no status reads. After RB_SETTLE clocks it reports success on the first clock that ry_by is 1.
- R9: If completion is not seen within POLL_LIMIT polls, the block reports a timeout. A poll is one pair of status reads (a confirming pair is not counted) or one clock of ry_by low. No reset write is issued on a timeout.
- R10: From the cycle after a request is accepted until its response, req_ready is 0 and any request presented is ignored.
- R11: Each response is a one-cycle resp_valid pulse with exactly one of resp_ok, resp_fail and resp_timeout set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 0 word write, 1 sector erase, 2 whole-array erase |
| req_addr | input | ADDR_W | Target word address or sector address |
| req_data | input | DATA_W | Word to write |
| req_rb_mode | input | 1 | 1: use the ready/busy pin, 0: use the status toggle bit |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_ok | output | 1 | Operation completed |
| resp_fail | output | 1 | Device reported an error |
| resp_timeout | output | 1 | Poll limit reached |
| flash_ce_n | output | 1 | Chip select, active low |
| flash_oe_n | output | 1 | Output strobe, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_addr | output | ADDR_W | Flash address |
| flash_dq_o | output | DATA_W | Data toward the flash |
| flash_dq_i | input | DATA_W | Data from the flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_o |
| flash_ry_by | input | 1 | Flash ready (1) or busy (0) |

## Verification
The checker watches every cycle for the bus rules: no output strobe during a drive or a write strobe, the write strobe only inside chip select with the bus driven, and address and data steady while the strobe is low. It also checks that req_ready drops after an accept and that each response is a single pulse with exactly one outcome. The bench's flash model is needed to show that the command sequences are correct and that phase widths are exact. Only its scenarios can show the completion outcomes, the poll-count limit, the read-twice-again path and its reset write, and that requests made while busy are ignored.

// File: rtl/flash_pe_pkg.sv
// Shared types and command codes for the flash program/erase sequencer.
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_WORD_WRITE  = 2'd0,
        OP_SECTOR_WIPE = 2'd1,
        OP_ARRAY_WIPE  = 2'd2,
        OP_RESERVED    = 2'd3
    } fpe_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_FAIL    = 2'd1,
        RES_TIMEOUT = 2'd2
    } fpe_res_e;

    localparam logic [7:0] CODE_KEY_A    = 8'hAA;
    localparam logic [7:0] CODE_KEY_B    = 8'h55;
    localparam logic [7:0] CODE_WR_ARM   = 8'hA0;
    localparam logic [7:0] CODE_WIPE_ARM = 8'h80;
    localparam logic [7:0] CODE_SECT_GO  = 8'h30;
    localparam logic [7:0] CODE_ARRAY_GO = 8'h10;
    localparam logic [7:0] CODE_ABORT    = 8'hF0;

endpackage

// File: rtl/fpe_cmd_table.sv
// Command step table.
// Maps an operation and a step index to the address/data pair of that
// bus write, and flags the final step. Purely combinational.
// Assumes step never exceeds the final step of the operation.
module fpe_cmd_table
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(16'h555),
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(16'h2AA)
) (
    input  fpe_op_e           op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              is_last
);

    // Select the write for the current step of the current operation.
    always_comb begin
        wr_addr = KEY_ADDR_A;
        wr_data = DATA_W'(CODE_KEY_A);
        is_last = 1'b0;
        if (op == OP_WORD_WRITE || op == OP_RESERVED) begin
            case (step)
                3'd0: begin wr_addr = KEY_ADDR_A; wr_data = DATA_W'(CODE_KEY_A); end
                3'd1: begin wr_addr = KEY_ADDR_B; wr_data = DATA_W'(CODE_KEY_B); end
                3'd2: begin wr_addr = KEY_ADDR_A; wr_data = DATA_W'(CODE_WR_ARM); end
                default: begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                    is_last = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin wr_addr = KEY_ADDR_A; wr_data = DATA_W'(CODE_KEY_A); end
                3'd1: begin wr_addr = KEY_ADDR_B; wr_data = DATA_W'(CODE_KEY_B); end
                3'd2: begin wr_addr = KEY_ADDR_A; wr_data = DATA_W'(CODE_WIPE_ARM); end
                3'd3: begin wr_addr = KEY_ADDR_A; wr_data = DATA_W'(CODE_KEY_A); end
                3'd4: begin wr_addr = KEY_ADDR_B; wr_data = DATA_W'(CODE_KEY_B); end
                default: begin
                    is_last = 1'b1;
                    if (op == OP_SECTOR_WIPE) begin
                        wr_addr = tgt_addr;
                        wr_data = DATA_W'(CODE_SECT_GO);
                    end else begin
                        wr_addr = KEY_ADDR_A;
                        wr_data = DATA_W'(CODE_ARRAY_GO);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fpe_bus_cycle.sv
// Single flash bus cycle engine.
// Runs one read or one write as setup, strobe and hold phases, each a
// parameter-set number of clocks (each at least 1). All pin outputs are
// registered. A read samples the data input on the last strobe clock.
// Assumes start is only raised while the engine is idle.
module fpe_bus_cycle #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 3,
    parameter int T_HOLD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [DATA_W-1:0] pin_dq,
    output logic              pin_dq_oe,
    input  logic [DATA_W-1:0] pin_dq_in
);

    localparam int T_MAX = (T_SETUP > T_STROBE) ?
                           ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                           ((T_STROBE > T_HOLD) ? T_STROBE : T_HOLD);
    localparam int CW = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    // Phase sequencing and pin drive for one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            rd_q      <= 1'b0;
            done      <= 1'b0;
            rdata     <= '0;
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            pin_addr  <= '0;
            pin_dq    <= '0;
            pin_dq_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph        <= PH_SETUP;
                        cnt       <= CW'(T_SETUP - 1);
                        rd_q      <= is_read;
                        pin_addr  <= addr;
                        pin_dq    <= wdata;
                        ce_n      <= 1'b0;
                        oe_n      <= !is_read;
                        pin_dq_oe <= !is_read;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_STROBE;
                        cnt <= CW'(T_STROBE - 1);
                        if (!rd_q) begin
                            we_n <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        ph   <= PH_HOLD;
                        cnt  <= CW'(T_HOLD - 1);
                        we_n <= 1'b1;
                        oe_n <= 1'b1;
                        if (rd_q) begin
                            rdata <= pin_dq_in;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        ph        <= PH_IDLE;
                        ce_n      <= 1'b1;
                        pin_dq_oe <= 1'b0;
                        done      <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fpe_sequencer.sv
// Operation sequencer.
// Accepts one request, walks its command steps through the bus engine,
// then polls for completion by toggle-bit reads or by the ready/busy
// pin, and produces a single response. It also owns the abort write
// after a confirmed error.
// Assumes the bus engine raises done once per started cycle.
module fpe_sequencer
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 1000,
    parameter int RB_SETTLE  = 4,
    parameter int TOG_BIT    = 6,
    parameter int ERR_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_rb_mode,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              resp_fail,
    output logic              resp_timeout,
    output logic              bus_start,
    output logic              bus_read,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              ry_by
);

    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam int SCW = $clog2(RB_SETTLE + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_CMD_W, S_SETTLE, S_RB_WAIT,
        S_RD_A, S_RD_A_W, S_RD_B, S_RD_B_W, S_EVAL,
        S_ABORT, S_ABORT_W, S_RESP
    } seq_e;

    seq_e              st;
    fpe_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              rb_q;
    logic [2:0]        step_q;
    logic [PCW-1:0]    poll_cnt;
    logic [SCW-1:0]    settle_cnt;
    logic              prev_tog;
    logic              cur_tog;
    logic              cur_err;
    logic              confirm_q;
    fpe_res_e          res_q;

    logic [ADDR_W-1:0] tbl_addr;
    logic [DATA_W-1:0] tbl_data;
    logic              tbl_last;
    logic              unused_rdata_bits;

    assign unused_rdata_bits = ^bus_rdata;

    fpe_cmd_table #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_table (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .is_last  (tbl_last)
    );

    // Bus requests follow directly from the launching states.
    always_comb begin
        bus_start = (st == S_CMD) || (st == S_RD_A) || (st == S_RD_B) || (st == S_ABORT);
        bus_read  = (st == S_RD_A) || (st == S_RD_B);
        bus_addr  = addr_q;
        bus_wdata = tbl_data;
        if (st == S_CMD) begin
            bus_addr = tbl_addr;
        end else if (st == S_ABORT) begin
            bus_addr  = '0;
            bus_wdata = DATA_W'(CODE_ABORT);
        end
    end

    // Handshake and response outputs decoded from state.
    always_comb begin
        req_ready    = (st == S_IDLE);
        resp_valid   = (st == S_RESP);
        resp_ok      = (st == S_RESP) && (res_q == RES_OK);
        resp_fail    = (st == S_RESP) && (res_q == RES_FAIL);
        resp_timeout = (st == S_RESP) && (res_q == RES_TIMEOUT);
    end

    // Main operation state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            op_q       <= OP_WORD_WRITE;
            addr_q     <= '0;
            data_q     <= '0;
            rb_q       <= 1'b0;
            step_q     <= '0;
            poll_cnt   <= '0;
            settle_cnt <= '0;
            prev_tog   <= 1'b0;
            cur_tog    <= 1'b0;
            cur_err    <= 1'b0;
            confirm_q  <= 1'b0;
            res_q      <= RES_OK;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q      <= fpe_op_e'(req_op);
                        addr_q    <= req_addr;
                        data_q    <= req_data;
                        rb_q      <= req_rb_mode;
                        step_q    <= '0;
                        poll_cnt  <= '0;
                        confirm_q <= 1'b0;
                        st        <= S_CMD;
                    end
                end
                S_CMD: st <= S_CMD_W;
                S_CMD_W: begin
                    if (bus_done) begin
                        if (tbl_last) begin
                            if (rb_q) begin
                                settle_cnt <= SCW'(RB_SETTLE);
                                st         <= S_SETTLE;
                            end else begin
                                st <= S_RD_A;
                            end
                        end else begin
                            step_q <= step_q + 1'b1;
                            st     <= S_CMD;
                        end
                    end
                end
                S_SETTLE: begin
                    if (settle_cnt <= SCW'(1)) begin
                        st <= S_RB_WAIT;
                    end else begin
                        settle_cnt <= settle_cnt - 1'b1;
                    end
                end
                S_RB_WAIT: begin
                    if (ry_by) begin
                        res_q <= RES_OK;
                        st    <= S_RESP;
                    end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                        res_q <= RES_TIMEOUT;
                        st    <= S_RESP;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                S_RD_A: st <= S_RD_A_W;
                S_RD_A_W: begin
                    if (bus_done) begin
                        prev_tog <= bus_rdata[TOG_BIT];
                        st       <= S_RD_B;
                    end
                end
                S_RD_B: st <= S_RD_B_W;
                S_RD_B_W: begin
                    if (bus_done) begin
                        cur_tog <= bus_rdata[TOG_BIT];
                        cur_err <= bus_rdata[ERR_BIT];
                        st      <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (prev_tog == cur_tog) begin
                        res_q <= RES_OK;
                        st    <= S_RESP;
                    end else if (confirm_q) begin
                        res_q <= RES_FAIL;
                        st    <= S_ABORT;
                    end else if (cur_err) begin
                        confirm_q <= 1'b1;
                        st        <= S_RD_A;
                    end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                        res_q <= RES_TIMEOUT;
                        st    <= S_RESP;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        st       <= S_RD_A;
                    end
                end
                S_ABORT: st <= S_ABORT_W;
                S_ABORT_W: begin
                    if (bus_done) begin
                        st <= S_RESP;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
// Flash program/erase controller, top level.
// Joins the operation sequencer to the bus cycle engine. The data bus is
// split into output, input and drive enable; the tristate buffer lives
// outside this block.
// Assumes ry_by and flash_dq_i are already synchronous to clk.
module flash_pe_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int T_SETUP    = 2,
    parameter int T_STROBE   = 3,
    parameter int T_HOLD     = 2,
    parameter int POLL_LIMIT = 1000,
    parameter int RB_SETTLE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_rb_mode,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              resp_fail,
    output logic              resp_timeout,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dq_o,
    input  logic [DATA_W-1:0] flash_dq_i,
    output logic              flash_dq_oe,
    input  logic              flash_ry_by
);

    logic              bus_start;
    logic              bus_read;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_done;
    logic [DATA_W-1:0] bus_rdata;

    fpe_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_LIMIT (POLL_LIMIT),
        .RB_SETTLE  (RB_SETTLE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_rb_mode  (req_rb_mode),
        .resp_valid   (resp_valid),
        .resp_ok      (resp_ok),
        .resp_fail    (resp_fail),
        .resp_timeout (resp_timeout),
        .bus_start    (bus_start),
        .bus_read     (bus_read),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_done     (bus_done),
        .bus_rdata    (bus_rdata),
        .ry_by        (flash_ry_by)
    );

    fpe_bus_cycle #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .T_SETUP  (T_SETUP),
        .T_STROBE (T_STROBE),
        .T_HOLD   (T_HOLD)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bus_start),
        .is_read   (bus_read),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .done      (bus_done),
        .rdata     (bus_rdata),
        .ce_n      (flash_ce_n),
        .oe_n      (flash_oe_n),
        .we_n      (flash_we_n),
        .pin_addr  (flash_addr),
        .pin_dq    (flash_dq_o),
        .pin_dq_oe (flash_dq_oe),
        .pin_dq_in (flash_dq_i)
    );

endmodule

// File: rtl/fpe_checker.sv
// Protocol checker for flash_pe_ctrl, attached by bind.
// Watches the flash pins and the request/response handshake.
module fpe_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_ok,
    input logic              resp_fail,
    input logic              resp_timeout,
    input logic              flash_ce_n,
    input logic              flash_oe_n,
    input logic              flash_we_n,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [DATA_W-1:0] flash_dq_o,
    input logic              flash_dq_oe
);

    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> (!flash_dq_oe && flash_we_n));

    a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (!flash_ce_n && flash_dq_oe));

    a_r4_steady_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |=> (flash_we_n || ($stable(flash_addr) && $stable(flash_dq_o))));

    a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (!flash_ce_n && $stable(flash_addr) && $stable(flash_dq_o)));

    a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_no_resp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !resp_valid);

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_ok, resp_fail, resp_timeout}) == 1));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r11_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> ({resp_ok, resp_fail, resp_timeout} == 3'b000));

endmodule

bind flash_pe_ctrl fpe_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_ok      (resp_ok),
    .resp_fail    (resp_fail),
    .resp_timeout (resp_timeout),
    .flash_ce_n   (flash_ce_n),
    .flash_oe_n   (flash_oe_n),
    .flash_we_n   (flash_we_n),
    .flash_addr   (flash_addr),
    .flash_dq_o   (flash_dq_o),
    .flash_dq_oe  (flash_dq_oe)
);

// File: tb/flash_pe_ctrl_tb.sv
// Directed bench for flash_pe_ctrl with a behavioural flash model.
module flash_pe_ctrl_tb;

    localparam int AW     = 16;
    localparam int DW     = 16;
    localparam int TS     = 2;
    localparam int TW     = 3;
    localparam int TH     = 2;
    localparam int LIMIT  = 12;
    localparam int SETTLE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_rb_mode = 1'b0;
    logic          resp_valid, resp_ok, resp_fail, resp_timeout;
    logic          ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] dq_o;
    logic [DW-1:0] model_q = 16'h1234;
    logic          ry_by;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Flash model state
    logic [AW-1:0] wlog_a [0:15];
    logic [DW-1:0] wlog_d [0:15];
    int   wcnt = 0;
    int   rd_count = 0;
    int   exp_len = 4;
    int   arm_reads = 0;
    int   arm_rb = 0;
    logic arm_err = 1'b0;
    int   busy_reads = 0;
    int   rb_clks = 0;
    logic err_flag = 1'b0;
    logic tog = 1'b0;
    int   tim_err = 0;
    int   cont_err = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, in_hold = 1'b0;
    int   pre_cnt = 0, low_cnt = 0, post_cnt = 0;
    logic [AW-1:0] fall_a;
    logic [DW-1:0] fall_d;

    assign ry_by = (rb_clks == 0);

    flash_pe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_STROBE(TW), .T_HOLD(TH),
        .POLL_LIMIT(LIMIT), .RB_SETTLE(SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_rb_mode(req_rb_mode), .resp_valid(resp_valid), .resp_ok(resp_ok),
        .resp_fail(resp_fail), .resp_timeout(resp_timeout), .flash_ce_n(ce_n),
        .flash_oe_n(oe_n), .flash_we_n(we_n), .flash_addr(f_addr),
        .flash_dq_o(dq_o), .flash_dq_i(model_q), .flash_dq_oe(dq_oe),
        .flash_ry_by(ry_by)
    );

    always #4 clk = ~clk;

    // Flash model and pin-timing monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (rst_n) begin
            if (!oe_n && (dq_oe || !we_n)) cont_err = cont_err + 1;
            if (rb_clks > 0) rb_clks = rb_clks - 1;
            if (ce_n) begin
                if (in_hold && post_cnt != TH) tim_err = tim_err + 1;
                in_hold = 1'b0;
                pre_cnt = 0;
            end else if (!we_n && prev_we) begin
                if (pre_cnt != TS) tim_err = tim_err + 1;
                fall_a = f_addr;
                fall_d = dq_o;
                low_cnt = 1;
            end else if (!we_n) begin
                low_cnt = low_cnt + 1;
            end else if (we_n && !prev_we) begin
                if (low_cnt != TW) tim_err = tim_err + 1;
                if (fall_a != f_addr || fall_d != dq_o || !dq_oe) tim_err = tim_err + 1;
                in_hold = 1'b1;
                post_cnt = 1;
                if (wcnt < 16) begin
                    wlog_a[wcnt] = f_addr;
                    wlog_d[wcnt] = dq_o;
                end
                if (dq_o == 16'h00F0) begin
                    busy_reads = 0;
                end else if (wcnt == exp_len - 1) begin
                    busy_reads = arm_reads;
                    rb_clks = arm_rb;
                    err_flag = arm_err;
                    tog = 1'b0;
                end
                wcnt = wcnt + 1;
            end else if (in_hold) begin
                post_cnt = post_cnt + 1;
            end else if (!oe_n && prev_oe) begin
                rd_count = rd_count + 1;
                if (busy_reads > 0) begin
                    tog = ~tog;
                    busy_reads = busy_reads - 1;
                    model_q = 16'h0000;
                    model_q[6] = tog;
                    model_q[5] = err_flag;
                end else begin
                    model_q = 16'h1234;
                end
            end else if (we_n && oe_n) begin
                pre_cnt = pre_cnt + 1;
            end
        end
        prev_we = we_n;
        prev_oe = oe_n;
    end

    task automatic chk(input logic cond, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!cond) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic arm(input int len, input int reads, input logic errb, input int rbc);
        wcnt = 0; rd_count = 0; tim_err = 0; cont_err = 0;
        exp_len = len; arm_reads = reads; arm_err = errb; arm_rb = rbc;
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rb);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_rb_mode = rb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp(output logic [2:0] res);
        res = 3'b000;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (resp_valid) begin
                res = {resp_ok, resp_fail, resp_timeout};
                return;
            end
        end
        chk(1'b0, "R11 response missing", 0, 1);
    endtask

    task automatic t_reset();
        chk(ce_n && oe_n && we_n, "R1 strobes high", {ce_n, oe_n, we_n}, 3'b111);
        chk(!dq_oe, "R1 bus released", dq_oe, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        chk(!resp_valid, "R1 no response", resp_valid, 0);
    endtask

    task automatic t_word_write();
        logic [2:0] res;
        arm(4, 3, 1'b0, 0);
        send(2'd0, 16'h1234, 16'hBEEF, 1'b0);
        wait_resp(res);
        chk(res == 3'b100, "R6 ok after toggle stops", res, 3'b100);
        chk(wcnt == 4, "R2 write count", wcnt, 4);
        chk(wlog_a[0] == 16'h555 && wlog_d[0] == 16'hAA, "R2 step0", {wlog_a[0], wlog_d[0]}, 32'h055500AA);
        chk(wlog_a[1] == 16'h2AA && wlog_d[1] == 16'h55, "R2 step1", {wlog_a[1], wlog_d[1]}, 32'h02AA0055);
        chk(wlog_a[2] == 16'h555 && wlog_d[2] == 16'hA0, "R2 step2", {wlog_a[2], wlog_d[2]}, 32'h055500A0);
        chk(wlog_a[3] == 16'h1234 && wlog_d[3] == 16'hBEEF, "R2 step3", {wlog_a[3], wlog_d[3]}, 32'h1234BEEF);
        chk(tim_err == 0, "R4 phase timing", tim_err, 0);
        chk(cont_err == 0, "R5 contention", cont_err, 0);
    endtask

    task automatic t_erase(input logic [1:0] op);
        logic [2:0] res;
        logic [15:0] ea, ed;
        arm(6, 5, 1'b0, 0);
        send(op, 16'h8000, 16'h0, 1'b0);
        wait_resp(res);
        ea = (op == 2'd1) ? 16'h8000 : 16'h555;
        ed = (op == 2'd1) ? 16'h30 : 16'h10;
        chk(res == 3'b100, "R6 erase ok", res, 3'b100);
        chk(wcnt == 6, "R3 write count", wcnt, 6);
        chk(wlog_d[2] == 16'h80 && wlog_a[3] == 16'h555 && wlog_d[4] == 16'h55,
            "R3 second unlock", {wlog_d[2], wlog_d[4]}, 32'h00800055);
        chk(wlog_a[5] == ea && wlog_d[5] == ed, "R3 final write", {wlog_a[5], wlog_d[5]}, {ea, ed});
        chk(tim_err == 0 && cont_err == 0, "R4 R5 erase bus rules", tim_err + cont_err, 0);
    endtask

    task automatic t_rb_mode();
        logic [2:0] res;
        arm(4, 0, 1'b0, 15);
        send(2'd0, 16'h0042, 16'h5A5A, 1'b1);
        wait_resp(res);
        chk(res == 3'b100, "R8 ok via pin", res, 3'b100);
        chk(rb_clks == 0, "R8 waited for ready", rb_clks, 0);
        chk(rd_count == 0, "R8 no status reads", rd_count, 0);
    endtask

    task automatic t_err_confirmed();
        logic [2:0] res;
        arm(4, 1000000, 1'b1, 0);
        send(2'd0, 16'h0010, 16'h0001, 1'b0);
        wait_resp(res);
        chk(res == 3'b010, "R7 fail reported", res, 3'b010);
        chk(rd_count == 4, "R7 four reads", rd_count, 4);
        chk(wcnt == 5 && wlog_a[4] == 16'h0 && wlog_d[4] == 16'hF0, "R7 abort write",
            {wlog_a[4], wlog_d[4]}, 32'h000000F0);
    endtask

    task automatic t_err_recovers();
        logic [2:0] res;
        arm(4, 2, 1'b1, 0);
        send(2'd0, 16'h0020, 16'h0002, 1'b0);
        wait_resp(res);
        chk(res == 3'b100, "R7 recovered ok", res, 3'b100);
        chk(rd_count == 4 && wcnt == 4, "R7 no abort on recovery", {rd_count, wcnt}, {32'd4, 32'd4});
    endtask

    task automatic t_timeout_toggle();
        logic [2:0] res;
        arm(4, 1000000, 1'b0, 0);
        send(2'd0, 16'h0030, 16'h0003, 1'b0);
        wait_resp(res);
        chk(res == 3'b001, "R9 toggle timeout", res, 3'b001);
        chk(rd_count == 2 * LIMIT, "R9 poll pairs", rd_count, 2 * LIMIT);
        chk(wcnt == 4, "R9 no abort write", wcnt, 4);
    endtask

    task automatic t_timeout_pin();
        logic [2:0] res;
        arm(4, 0, 1'b0, 100000);
        send(2'd0, 16'h0040, 16'h0004, 1'b1);
        wait_resp(res);
        chk(res == 3'b001, "R9 pin timeout", res, 3'b001);
        arm(0, 0, 1'b0, 0);
        rb_clks = 0;
    endtask

    task automatic t_busy_ignore();
        logic [2:0] res;
        arm(6, 20, 1'b0, 0);
        send(2'd1, 16'h4000, 16'h0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            req_valid = 1'b1; req_op = 2'd0; req_addr = 16'h7777; req_data = 16'h1111;
            @(negedge clk);
            if (i == 10) chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;
        wait_resp(res);
        chk(res == 3'b100, "R10 busy op completes", res, 3'b100);
        repeat (30) @(negedge clk);
        chk(wcnt == 6, "R10 extra request ignored", wcnt, 6);
        chk(req_ready, "R10 ready after response", req_ready, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cycles > 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_write();
        t_erase(2'd1);
        t_erase(2'd2);
        t_rb_mode();
        t_err_confirmed();
        t_err_recovers();
        t_timeout_toggle();
        t_timeout_pin();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule